// File: doc/BRIEF.md
# Printer Port Register Block

This block is a byte-wide register file for a classic host-driven printer port. A host bus issues single-cycle reads and writes at a 3-bit register offset. Behind the offsets sit an output data latch, an input data latch, a status register and a control register. The block does not drive real pins. It models the printer handshake internally. When software raises the strobe, the block hands the latched byte to a valid/ready output stream. When software reads status, the block steps the busy and acknowledge bits through a fixed sequence. The block also raises a level interrupt.

Two state machines carry the sequential behaviour. The handshake machine `hs_state_e` has three states, named after the status BUSY and ACK bits. `HS_BUSY_ACK` is entered at reset and on any control write with INIT clear. A control write that clears BUSY moves it to `HS_FREE_ACK`; this is the "strobe" transition. A status read with BUSY clear and the stored strobe low moves `HS_FREE_ACK` to `HS_FREE_NOACK`; this is the "ack-drop" transition. The same kind of read moves `HS_FREE_NOACK` back to `HS_BUSY_ACK`; this is the "ack-return" transition. The output machine `os_state_e` has two states. `OS_IDLE` moves to `OS_HOLD` when a strobe edge loads a byte. `OS_HOLD` returns to `OS_IDLE` in the cycle the consumer asserts ready.

Register reads are combinational from the stored state. Every side effect, whether of a write or of a status read, takes place on the clock edge of the access.

Top module: `lpt_regfile`

## Requirements
- R1: After reset: reading data returns 0xFF, reading status returns 0xD8 and reading control returns 0x0C. The interrupt is low and out_valid is low.
- R2: Offset 0 is data, 1 is status and 2 is control. Reads at offsets 3 to 7 return 0xFF. Writes there change no register, and a write at offset 1 also changes nothing.
- R3: A data read returns the input latch (0xFF) when control bit 5 (direction) is 1. It returns the last byte written at offset 0 when that bit is 0.
- R4: A control write with bit 2 (INIT) equal to 0 sets status to 0xD8, whatever the other bits are.
- R5: A control write with INIT=1, bit 3 (SELECT)=1 and bit 0 (STROBE)=1 clears status bit 7 (BUSY).
- R6: The write in R5 sends the output data byte exactly once, with out_valid high from the next cycle, but only when the stored STROBE was 0 before the write. With stored STROBE=1 or SELECT=0, nothing is sent.
- R7: While out_valid is high and out_ready is low, out_valid and out_data hold. A strobe edge that arrives while a byte is still pending is dropped.
- R8: A control write with INIT=1, SELECT=1 and STROBE=0 sets the interrupt from the next cycle when the previously stored bit 4 (IRQ enable) is 1. The enable bit carried by that write itself does not count.
- R9: A status read returns the current status and lowers the interrupt from the next cycle. Data reads, control reads and data writes leave the interrupt as it is.
- R10: A status read with BUSY=0 and stored STROBE=0 clears ACK (bit 6) if ACK was set. If ACK was clear, the read sets both ACK and BUSY. With stored STROBE=1 the status does not change. The other status bits are fixed: bit 5=0, bit 4=1, bit 3=1, bit 0=0.
- R11: A control read returns the full 8-bit value last written to control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| out_valid | output | 1 | A sent byte is pending |
| out_ready | input | 1 | The consumer takes the pending byte |
| out_data | output | 8 | Sent byte |
| irq | output | 1 | Level interrupt |

## Verification
The properties assume the host never asserts bus_rd and bus_wr in the same cycle. They also assume out_ready is a clean level sampled at the clock. The bench issues every access through one read task or one write task that raises a single strobe for exactly one cycle. It changes out_ready only on the falling edge, so both assumptions hold throughout. The handshake properties observe the internal status byte through the bind. This lets a control write's effect on BUSY be checked in the following cycle without a status read, which would itself disturb the sequence.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    localparam int REG_W = 8;
    localparam int OFS_W = 3;

    localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
    localparam logic [OFS_W-1:0] OFS_STAT = 3'd1;
    localparam logic [OFS_W-1:0] OFS_CTRL = 3'd2;

    // status bit positions
    localparam int SB_BUSY   = 7;
    localparam int SB_ACK    = 6;
    localparam int SB_PAPER  = 5;
    localparam int SB_ONLINE = 4;
    localparam int SB_ERR    = 3;
    localparam int SB_TMO    = 0;

    // control bit positions
    localparam int CB_DIR  = 5;
    localparam int CB_IEN  = 4;
    localparam int CB_SEL  = 3;
    localparam int CB_INIT = 2;
    localparam int CB_ALF  = 1;
    localparam int CB_STB  = 0;

    localparam logic [REG_W-1:0] CTRL_RST   = REG_W'((1 << CB_SEL) | (1 << CB_INIT));
    localparam logic [REG_W-1:0] DATA_RST   = '1;
    localparam logic [REG_W-1:0] UNMAPPED_Q = '1;

    typedef enum logic [1:0] {
        HS_BUSY_ACK   = 2'd0,
        HS_FREE_ACK   = 2'd1,
        HS_FREE_NOACK = 2'd2
    } hs_state_e;

    typedef enum logic {
        OS_IDLE = 1'b0,
        OS_HOLD = 1'b1
    } os_state_e;

    function automatic logic [REG_W-1:0] stat_byte(input logic busy, input logic ack);
        logic [REG_W-1:0] b;
        b            = '0;
        b[SB_BUSY]   = busy;
        b[SB_ACK]    = ack;
        b[SB_PAPER]  = 1'b0;
        b[SB_ONLINE] = 1'b1;
        b[SB_ERR]    = 1'b1;
        b[SB_TMO]    = 1'b0;
        return b;
    endfunction

endpackage

// File: rtl/lpt_decode.sv
module lpt_decode
    import lpt_pkg::*;
(
    input  logic [OFS_W-1:0] bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [REG_W-1:0] dataw_q,
    input  logic [REG_W-1:0] datar_q,
    input  logic [REG_W-1:0] stat_q,
    input  logic [REG_W-1:0] ctrl_q,
    output logic             wr_data,
    output logic             wr_ctrl,
    output logic             rd_stat,
    output logic [REG_W-1:0] rdata
);

    always_comb begin
        wr_data = bus_wr && (bus_addr == OFS_DATA);
        wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
        rd_stat = bus_rd && (bus_addr == OFS_STAT);
    end

    always_comb begin
        unique case (bus_addr)
            OFS_DATA: rdata = ctrl_q[CB_DIR] ? datar_q : dataw_q;
            OFS_STAT: rdata = stat_q;
            OFS_CTRL: rdata = ctrl_q;
            default:  rdata = UNMAPPED_Q;
        endcase
    end

endmodule

// File: rtl/lpt_hs_fsm.sv
module lpt_hs_fsm
    import lpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic [REG_W-1:0] wdata,
    input  logic             stb_stored,
    input  logic             rd_stat,
    output logic [REG_W-1:0] stat_q
);

    hs_state_e state_q, state_d;
    logic      busy, ack;

    always_ff @(posedge clk) begin
        if (rst) state_q <= HS_BUSY_ACK;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wr_ctrl) begin
            if (!wdata[CB_INIT]) begin
                state_d = HS_BUSY_ACK;
            end else if (wdata[CB_SEL] && wdata[CB_STB]) begin
                unique case (state_q)
                    HS_BUSY_ACK:   state_d = HS_FREE_ACK;
                    HS_FREE_ACK:   state_d = HS_FREE_ACK;
                    HS_FREE_NOACK: state_d = HS_FREE_NOACK;
                    default:       state_d = HS_BUSY_ACK;
                endcase
            end
        end else if (rd_stat && !stb_stored) begin
            unique case (state_q)
                HS_BUSY_ACK:   state_d = HS_BUSY_ACK;
                HS_FREE_ACK:   state_d = HS_FREE_NOACK;
                HS_FREE_NOACK: state_d = HS_BUSY_ACK;
                default:       state_d = HS_BUSY_ACK;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            HS_BUSY_ACK:   begin busy = 1'b1; ack = 1'b1; end
            HS_FREE_ACK:   begin busy = 1'b0; ack = 1'b1; end
            HS_FREE_NOACK: begin busy = 1'b0; ack = 1'b0; end
            default:       begin busy = 1'b1; ack = 1'b1; end
        endcase
        stat_q = stat_byte(busy, ack);
    end

endmodule

// File: rtl/lpt_out_fsm.sv
module lpt_out_fsm
    import lpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [REG_W-1:0] load_byte,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [REG_W-1:0] out_data
);

    os_state_e        state_q, state_d;
    logic [REG_W-1:0] byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OS_IDLE;
            byte_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == OS_IDLE && load) byte_q <= load_byte;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_IDLE: if (load)      state_d = OS_HOLD;
            OS_HOLD: if (out_ready) state_d = OS_IDLE;
            default:                state_d = OS_IDLE;
        endcase
    end

    always_comb begin
        out_valid = (state_q == OS_HOLD);
        out_data  = byte_q;
    end

endmodule

// File: rtl/lpt_regfile.sv
module lpt_regfile
    import lpt_pkg::*;
#(
    parameter int AW = OFS_W,
    parameter int DW = REG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic          irq
);

    logic [DW-1:0] dataw_q, datar_q, ctrl_q, stat_q;
    logic          irq_q;
    logic          wr_data, wr_ctrl, rd_stat;
    logic          send, irq_set;

    lpt_decode u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .dataw_q  (dataw_q),
        .datar_q  (datar_q),
        .stat_q   (stat_q),
        .ctrl_q   (ctrl_q),
        .wr_data  (wr_data),
        .wr_ctrl  (wr_ctrl),
        .rd_stat  (rd_stat),
        .rdata    (bus_rdata)
    );

    lpt_hs_fsm u_hs (
        .clk        (clk),
        .rst        (rst),
        .wr_ctrl    (wr_ctrl),
        .wdata      (bus_wdata),
        .stb_stored (ctrl_q[CB_STB]),
        .rd_stat    (rd_stat),
        .stat_q     (stat_q)
    );

    lpt_out_fsm u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (send),
        .load_byte (dataw_q),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // Strobe edge and interrupt conditions use the control value stored before this write.
    always_comb begin
        send    = wr_ctrl && bus_wdata[CB_INIT] && bus_wdata[CB_SEL]
                  && bus_wdata[CB_STB] && !ctrl_q[CB_STB];
        irq_set = wr_ctrl && bus_wdata[CB_INIT] && bus_wdata[CB_SEL]
                  && !bus_wdata[CB_STB] && ctrl_q[CB_IEN];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dataw_q <= DATA_RST;
            datar_q <= DATA_RST;
            ctrl_q  <= CTRL_RST;
            irq_q   <= 1'b0;
        end else begin
            if (wr_data) dataw_q <= bus_wdata;
            if (wr_ctrl) ctrl_q  <= bus_wdata;
            if (rd_stat)      irq_q <= 1'b0;
            else if (irq_set) irq_q <= 1'b1;
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/lpt_regfile_chk.sv
module lpt_regfile_chk
    import lpt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [OFS_W-1:0] bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [REG_W-1:0] bus_wdata,
    input logic [REG_W-1:0] bus_rdata,
    input logic             out_valid,
    input logic             out_ready,
    input logic [REG_W-1:0] out_data,
    input logic             irq,
    input logic [REG_W-1:0] stat_q
);

    logic c_wr, s_rd;
    assign c_wr = bus_wr && bus_addr == OFS_CTRL;
    assign s_rd = bus_rd && bus_addr == OFS_STAT;

    // R2
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr > OFS_CTRL) |-> bus_rdata == UNMAPPED_Q);

    // R4
    init_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (c_wr && !bus_wdata[CB_INIT]) |=> stat_q == stat_byte(1'b1, 1'b1));

    // R5
    busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (c_wr && bus_wdata[CB_INIT] && bus_wdata[CB_SEL] && bus_wdata[CB_STB]) |=> !stat_q[SB_BUSY]);

    // R6
    send_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(c_wr && bus_wdata[CB_STB] && bus_wdata[CB_SEL] && bus_wdata[CB_INIT]));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(c_wr && !bus_wdata[CB_STB]));

    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        s_rd |=> !irq);

endmodule

bind lpt_regfile lpt_regfile_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .irq       (irq),
    .stat_q    (stat_q)
);

// File: tb/tb_lpt_regfile.sv
module tb_lpt_regfile;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    lpt_regfile dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(3'd0, v); chk("R1 data", v, 8'hFF);
        rd(3'd2, v); chk("R1 ctrl", v, 8'h0C);
        rd(3'd1, v); chk("R1 status", v, 8'hD8);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 valid", {7'd0, out_valid}, 8'h00);
    endtask

    task automatic t_dir();
        logic [7:0] v;
        wr(3'd0, 8'h5A);
        rd(3'd0, v); chk("R3 dir0", v, 8'h5A);
        wr(3'd2, 8'h2C);
        rd(3'd0, v); chk("R3 dir1", v, 8'hFF);
        wr(3'd2, 8'h0C);
        rd(3'd0, v); chk("R3 dir0 again", v, 8'h5A);
    endtask

    task automatic t_decode();
        logic [7:0] v;
        for (int a = 3; a < 8; a++) begin
            wr(3'(a), 8'h00);
            rd(3'(a), v); chk("R2 unmapped read", v, 8'hFF);
        end
        wr(3'd1, 8'h00);
        rd(3'd0, v); chk("R2 data kept", v, 8'h5A);
        rd(3'd2, v); chk("R2 ctrl kept", v, 8'h0C);
        rd(3'd1, v); chk("R2 status kept", v, 8'hD8);
        chk("R2 no send", {7'd0, out_valid}, 8'h00);
    endtask

    task automatic t_strobe();
        logic [7:0] v;
        wr(3'd0, 8'h33);
        wr(3'd2, 8'h0D);
        chk("R6 valid", {7'd0, out_valid}, 8'h01);
        chk("R6 byte", out_data, 8'h33);
        repeat (3) @(negedge clk);
        chk("R7 hold valid", {7'd0, out_valid}, 8'h01);
        chk("R7 hold byte", out_data, 8'h33);
        wr(3'd2, 8'h0C);
        wr(3'd0, 8'h44);
        wr(3'd2, 8'h0D);
        chk("R7 drop byte", out_data, 8'h33);
        @(negedge clk); out_ready = 1'b1;
        @(negedge clk); out_ready = 1'b0;
        chk("R7 accepted", {7'd0, out_valid}, 8'h00);
        @(negedge clk);
        chk("R7 no second byte", {7'd0, out_valid}, 8'h00);
        rd(3'd1, v); chk("R5 busy clear", v, 8'h58);
        rd(3'd1, v); chk("R10 stb1 no advance", v, 8'h58);
        wr(3'd2, 8'h0D);
        chk("R6 stored stb1 no send", {7'd0, out_valid}, 8'h00);
    endtask

    task automatic t_ack();
        logic [7:0] v;
        wr(3'd2, 8'h0C);
        rd(3'd1, v); chk("R10 ack set", v, 8'h58);
        rd(3'd1, v); chk("R10 ack dropped", v, 8'h18);
        rd(3'd1, v); chk("R10 ack busy back", v, 8'hD8);
        rd(3'd1, v); chk("R10 busy holds", v, 8'hD8);
    endtask

    task automatic t_init();
        logic [7:0] v;
        wr(3'd2, 8'h0D);
        chk("R6 second send", out_data, 8'h44);
        @(negedge clk); out_ready = 1'b1;
        @(negedge clk); out_ready = 1'b0;
        wr(3'd2, 8'h09);
        rd(3'd1, v); chk("R4 init reload", v, 8'hD8);
        wr(3'd2, 8'h04);
        wr(3'd2, 8'h05);
        chk("R6 sel0 no send", {7'd0, out_valid}, 8'h00);
        rd(3'd1, v); chk("R5 sel0 busy kept", v, 8'hD8);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wr(3'd2, 8'h1C);
        chk("R8 old enable 0", {7'd0, irq}, 8'h00);
        wr(3'd2, 8'h1C);
        chk("R8 irq set", {7'd0, irq}, 8'h01);
        rd(3'd2, v); chk("R11 ctrl readback", v, 8'h1C);
        rd(3'd0, v);
        wr(3'd0, 8'h77);
        chk("R9 irq kept", {7'd0, irq}, 8'h01);
        rd(3'd1, v); chk("R9 status value", v, 8'hD8);
        chk("R9 irq cleared", {7'd0, irq}, 8'h00);
        wr(3'd2, 8'h0C);
        chk("R8 old enable counts", {7'd0, irq}, 8'h01);
        rd(3'd1, v);
        chk("R9 cleared again", {7'd0, irq}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_dir();
        t_decode();
        t_strobe();
        t_ack();
        t_init();
        t_irq();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=00 expected=01");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule